// File: doc/BRIEF.md
# I2C Slave Command Sequencer

This block is the byte-level control engine of an I2C slave. A bit-level front end tells it about bus events: a start or repeated start, a stop, a matched address byte with its R/W bit, a received data byte, and the master's ACK or NACK after a byte the slave has sent. The sequencer turns these events into three flags: address-match, data-ready and stop-received. It holds SCL low while an address-match or data-ready flag is waiting. It then decodes a two-bit command strobe from software, together with the captured transfer direction and the pending flag. From that it drives the acknowledge bit, arms the receiver for the next byte, loads a byte for transmission, or releases the bus until the next start.

A configuration bit selects ACK (0) or NACK (1) as the acknowledge action. In smart mode, reading a received byte issues that acknowledge and re-arms the receiver, so software needs no command. In group-command mode, a stop raises the stop-received flag only when this slave was addressed since the previous stop.

Received bytes leave through a valid/ready port. `rx_valid_o` stays high and `rx_data_o` stays stable while the data-ready flag of a master-write is pending. A handshake (`rx_valid_o && rx_ready_i`) counts as a read of the byte. It has an effect only in smart mode. With smart mode off, holding `rx_ready_i` low or high changes nothing, and the byte stays offered until a command is written. All other pins are plain level or single-cycle pulse signals. All outputs are registered and change one clock after the input that causes them.

Top module: `i2c_cmd_seq`

## Requirements
- R1: After reset, and again on any later reset, all three flags are 0, `scl_hold_o`, `dir_o`, `ack_pulse_o`, `rx_arm_o` and `tx_load_o` are 0, and `bus_release_o` is 1.
- R2: A start moves the sequencer to the address phase and clears `dir_o` to 0. In that phase a matched address pulse sets address-match and captures the R/W bit into `dir_o` (1 = master-read). `dir_o` then holds its value until the next start.
- R3: Writing command code 2 or 3 clears all three flags. Writing code 0 or code 1 changes no flag and no other output.
- R4: Command 3 with address-match pending gives one `ack_pulse_o` cycle, with `ack_nack_o` equal to the acknowledge setting (0 = ACK, 1 = NACK). In a master-write it then arms the receiver (`rx_arm_o`=1). In a master-read it sets data-ready and SCL stays held.
- R5: A received byte while the receiver is armed sets data-ready and holds SCL. In a master-write it presents the byte on `rx_data_o` with `rx_valid_o`=1.
- R6: With smart mode off and data-ready pending in a master-write, command 3 acknowledges and re-arms the receiver. Command 2 acknowledges and then releases the bus (`bus_release_o`=1).
- R7: With data-ready pending in a master-read, command 3 pulses `tx_load_o` with `tx_byte_o` equal to `tx_data_i`. The following master ACK/NACK sets data-ready and sets `mnack_o` to the NACK bit. Command 2 releases the bus with no acknowledge pulse.
- R8: With smart mode on, a read handshake of a pending master-write byte acknowledges it, clears data-ready and re-arms the receiver. A command on such a byte then issues no acknowledge pulse. With smart mode off, a read handshake changes nothing.
- R9: A stop releases the bus. With group mode off it always sets stop-received. With group mode on it sets stop-received only if an address matched since the previous stop.
- R10: If a command write and a stop occur in the same cycle, stop-received ends up set.
- R11: `scl_hold_o` is 1 exactly when address-match or data-ready is set, and those two flags are never set together. A start or stop drops both flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_ackact_i | input | 1 | Acknowledge action: 0 ACK, 1 NACK |
| cfg_smart_i | input | 1 | Smart mode enable |
| cfg_group_i | input | 1 | Group-command stop flag mode |
| cmd_wr_i | input | 1 | Command write strobe |
| cmd_i | input | 2 | Command code |
| fe_start_i | input | 1 | Start or repeated start detected |
| fe_stop_i | input | 1 | Stop detected |
| fe_addr_i | input | 1 | Matched address byte received |
| fe_rw_i | input | 1 | R/W bit of the address byte |
| fe_byte_i | input | 1 | Data byte received |
| fe_data_i | input | 8 | Received data byte |
| fe_mack_i | input | 1 | Master ACK/NACK received after a sent byte |
| fe_nack_i | input | 1 | 1 when the master answered NACK |
| tx_data_i | input | 8 | Byte to send in a master-read |
| rx_ready_i | input | 1 | Software reads the received byte |
| rx_valid_o | output | 1 | Received byte available |
| rx_data_o | output | 8 | Received byte |
| amatch_o | output | 1 | Address-match flag |
| drdy_o | output | 1 | Data-ready flag |
| prec_o | output | 1 | Stop-received flag |
| dir_o | output | 1 | Transfer direction, 1 = master-read |
| scl_hold_o | output | 1 | Stretch request to the front end |
| ack_pulse_o | output | 1 | Drive the acknowledge bit now |
| ack_nack_o | output | 1 | Acknowledge value during the pulse |
| rx_arm_o | output | 1 | Receiver armed for the next byte |
| tx_load_o | output | 1 | Start sending `tx_byte_o` |
| tx_byte_o | output | 8 | Byte handed to the front end |
| mnack_o | output | 1 | Last master response, 1 = NACK |
| bus_release_o | output | 1 | Bus released, waiting for a start |

## Verification
The assertions check several rules on every cycle:
- the coupling of the stretch request to the address-match and data-ready flags, and the exclusion of those two flags;
- the acknowledge value carried on each acknowledge pulse;
- flag clearing by commands 2 and 3, and the absence of any flag effect from codes 0 and 1;
- a transmit load only in a master-read;
- stop-received being set by every stop when group mode is off.

The bench scenarios show the rest: the decode of each command against direction and pending flag, the smart-mode read path, the group-mode qualification of a stop, and a command colliding with a stop.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
  localparam int CMD_W  = 2;
  localparam int NFLAG  = 3;
  localparam int FLG_AM = 0;
  localparam int FLG_DR = 1;
  localparam int FLG_PR = 2;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_RX,
    ST_TX,
    ST_WAIT
  } seq_state_e;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 2'd0,
    CMD_RSVD = 2'd1,
    CMD_DONE = 2'd2,
    CMD_NEXT = 2'd3
  } cmd_e;

  typedef struct packed {
    logic       clr_flags;
    logic       do_ack;
    logic       set_drdy;
    logic       load_tx;
    logic       go;
    seq_state_e nxt;
  } cmd_act_t;
endpackage

// File: rtl/i2cs_flag_bank.sv
module i2cs_flag_bank #(
  parameter int NF = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NF-1:0] set_i,
  input  logic [NF-1:0] clr_i,
  output logic [NF-1:0] q_o
);
  // a set in the same cycle as a clear wins
  for (genvar g = 0; g < NF; g++) begin : g_flag
    always_ff @(posedge clk) begin
      if (!rst_n) q_o[g] <= 1'b0;
      else        q_o[g] <= set_i[g] | (q_o[g] & ~clr_i[g]);
    end
  end
endmodule

// File: rtl/i2cs_cmd_decode.sv
module i2cs_cmd_decode
  import i2cs_pkg::*;
(
  input  logic             cmd_wr_i,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             waiting_i,
  input  logic             amatch_i,
  input  logic             drdy_i,
  input  logic             dir_i,
  input  logic             smart_i,
  output cmd_act_t         act_o
);
  logic live;
  logic data_ev;

  assign data_ev = drdy_i && !amatch_i;

  always_comb begin
    act_o     = '0;
    act_o.nxt = ST_WAIT;
    live      = 1'b0;
    if (cmd_wr_i) begin
      case (cmd_e'(cmd_i))
        CMD_DONE, CMD_NEXT: act_o.clr_flags = 1'b1;
        default:            act_o.clr_flags = 1'b0;
      endcase
    end
    live = act_o.clr_flags && waiting_i;
    if (live) begin
      act_o.go = 1'b1;
      if (cmd_e'(cmd_i) == CMD_DONE) begin
        act_o.nxt    = ST_IDLE;
        act_o.do_ack = !dir_i && !(smart_i && data_ev);
      end else if (amatch_i) begin
        act_o.do_ack = 1'b1;
        if (dir_i) begin
          act_o.set_drdy = 1'b1;
          act_o.nxt      = ST_WAIT;
        end else begin
          act_o.nxt = ST_RX;
        end
      end else if (data_ev) begin
        if (dir_i) begin
          act_o.load_tx = 1'b1;
          act_o.nxt     = ST_TX;
        end else begin
          act_o.do_ack = !smart_i;
          act_o.nxt    = ST_RX;
        end
      end else begin
        act_o.go = 1'b0;
      end
    end
  end
endmodule

// File: rtl/i2cs_seq_fsm.sv
module i2cs_seq_fsm
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fe_start_i,
  input  logic              fe_stop_i,
  input  logic              fe_addr_i,
  input  logic              fe_rw_i,
  input  logic              fe_byte_i,
  input  logic [DATA_W-1:0] fe_data_i,
  input  logic              fe_mack_i,
  input  logic              fe_nack_i,
  input  logic              rx_ready_i,
  input  logic              cfg_smart_i,
  input  logic              cfg_group_i,
  input  logic              cfg_ackact_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  cmd_act_t          act_i,
  input  logic              drdy_i,
  output seq_state_e        state_o,
  output logic              dir_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              ack_pulse_o,
  output logic              ack_nack_o,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              mnack_o,
  output logic [NFLAG-1:0]  set_o,
  output logic [NFLAG-1:0]  clr_o
);
  seq_state_e st_q, st_d;
  logic addressed_q;
  logic kill, ev_addr, ev_byte, ev_mack, smart_rd, ack_now;

  assign kill     = fe_start_i || fe_stop_i;
  assign ev_addr  = fe_addr_i && (st_q == ST_ADDR) && !kill;
  assign ev_byte  = fe_byte_i && (st_q == ST_RX) && !kill;
  assign ev_mack  = fe_mack_i && (st_q == ST_TX) && !kill;
  assign smart_rd = cfg_smart_i && (st_q == ST_WAIT) && drdy_i && !dir_o
                    && rx_ready_i && !kill;
  assign ack_now  = (act_i.do_ack || smart_rd) && !kill;

  always_comb begin
    set_o          = '0;
    clr_o          = '0;
    set_o[FLG_AM]  = ev_addr;
    set_o[FLG_DR]  = (ev_byte || ev_mack || act_i.set_drdy) && !kill;
    set_o[FLG_PR]  = fe_stop_i && (!cfg_group_i || addressed_q);
    clr_o[FLG_AM]  = act_i.clr_flags || kill;
    clr_o[FLG_DR]  = act_i.clr_flags || kill || smart_rd;
    clr_o[FLG_PR]  = act_i.clr_flags;
  end

  always_comb begin
    st_d = st_q;
    if (fe_start_i)                          st_d = ST_ADDR;
    else if (fe_stop_i)                      st_d = ST_IDLE;
    else if (ev_addr || ev_byte || ev_mack)  st_d = ST_WAIT;
    else if (act_i.go)                       st_d = act_i.nxt;
    else if (smart_rd)                       st_d = ST_RX;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q        <= ST_IDLE;
      dir_o       <= 1'b0;
      addressed_q <= 1'b0;
      rx_data_o   <= '0;
      ack_pulse_o <= 1'b0;
      ack_nack_o  <= 1'b0;
      tx_load_o   <= 1'b0;
      tx_byte_o   <= '0;
      mnack_o     <= 1'b0;
    end else begin
      st_q        <= st_d;
      ack_pulse_o <= ack_now;
      ack_nack_o  <= ack_now && cfg_ackact_i;
      tx_load_o   <= act_i.load_tx && !kill;
      if (fe_start_i)   dir_o <= 1'b0;
      else if (ev_addr) dir_o <= fe_rw_i;
      if (fe_stop_i)    addressed_q <= 1'b0;
      else if (ev_addr) addressed_q <= 1'b1;
      if (ev_byte)      rx_data_o <= fe_data_i;
      if (act_i.load_tx && !kill) tx_byte_o <= tx_data_i;
      if (ev_mack)      mnack_o <= fe_nack_i;
    end
  end

  assign state_o = st_q;
endmodule

// File: rtl/i2c_cmd_seq.sv
module i2c_cmd_seq
  import i2cs_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_ackact_i,
  input  logic              cfg_smart_i,
  input  logic              cfg_group_i,
  input  logic              cmd_wr_i,
  input  logic [1:0]        cmd_i,
  input  logic              fe_start_i,
  input  logic              fe_stop_i,
  input  logic              fe_addr_i,
  input  logic              fe_rw_i,
  input  logic              fe_byte_i,
  input  logic [DATA_W-1:0] fe_data_i,
  input  logic              fe_mack_i,
  input  logic              fe_nack_i,
  input  logic [DATA_W-1:0] tx_data_i,
  input  logic              rx_ready_i,
  output logic              rx_valid_o,
  output logic [DATA_W-1:0] rx_data_o,
  output logic              amatch_o,
  output logic              drdy_o,
  output logic              prec_o,
  output logic              dir_o,
  output logic              scl_hold_o,
  output logic              ack_pulse_o,
  output logic              ack_nack_o,
  output logic              rx_arm_o,
  output logic              tx_load_o,
  output logic [DATA_W-1:0] tx_byte_o,
  output logic              mnack_o,
  output logic              bus_release_o
);
  cmd_act_t         act;
  seq_state_e       st;
  logic [NFLAG-1:0] flg, fset, fclr;

  i2cs_cmd_decode u_dec (
    .cmd_wr_i  (cmd_wr_i),
    .cmd_i     (cmd_i),
    .waiting_i (st == ST_WAIT),
    .amatch_i  (flg[FLG_AM]),
    .drdy_i    (flg[FLG_DR]),
    .dir_i     (dir_o),
    .smart_i   (cfg_smart_i),
    .act_o     (act)
  );

  i2cs_seq_fsm #(.DATA_W(DATA_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .fe_start_i   (fe_start_i),
    .fe_stop_i    (fe_stop_i),
    .fe_addr_i    (fe_addr_i),
    .fe_rw_i      (fe_rw_i),
    .fe_byte_i    (fe_byte_i),
    .fe_data_i    (fe_data_i),
    .fe_mack_i    (fe_mack_i),
    .fe_nack_i    (fe_nack_i),
    .rx_ready_i   (rx_ready_i),
    .cfg_smart_i  (cfg_smart_i),
    .cfg_group_i  (cfg_group_i),
    .cfg_ackact_i (cfg_ackact_i),
    .tx_data_i    (tx_data_i),
    .act_i        (act),
    .drdy_i       (flg[FLG_DR]),
    .state_o      (st),
    .dir_o        (dir_o),
    .rx_data_o    (rx_data_o),
    .ack_pulse_o  (ack_pulse_o),
    .ack_nack_o   (ack_nack_o),
    .tx_load_o    (tx_load_o),
    .tx_byte_o    (tx_byte_o),
    .mnack_o      (mnack_o),
    .set_o        (fset),
    .clr_o        (fclr)
  );

  i2cs_flag_bank #(.NF(NFLAG)) u_flags (
    .clk   (clk),
    .rst_n (rst_n),
    .set_i (fset),
    .clr_i (fclr),
    .q_o   (flg)
  );

  assign amatch_o      = flg[FLG_AM];
  assign drdy_o        = flg[FLG_DR];
  assign prec_o        = flg[FLG_PR];
  assign scl_hold_o    = (st == ST_WAIT);
  assign rx_arm_o      = (st == ST_RX);
  assign bus_release_o = (st == ST_IDLE);
  assign rx_valid_o    = flg[FLG_DR] && !dir_o;
endmodule

// File: rtl/i2cs_seq_chk.sv
module i2cs_seq_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cmd_wr_i,
  input logic [1:0] cmd_i,
  input logic       fe_start_i,
  input logic       fe_stop_i,
  input logic       fe_addr_i,
  input logic       fe_byte_i,
  input logic       fe_mack_i,
  input logic       rx_ready_i,
  input logic       cfg_ackact_i,
  input logic       cfg_group_i,
  input logic       amatch_o,
  input logic       drdy_o,
  input logic       prec_o,
  input logic       dir_o,
  input logic       scl_hold_o,
  input logic       ack_pulse_o,
  input logic       ack_nack_o,
  input logic       tx_load_o
);
  // R11
  hold_matches_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
    scl_hold_o == (amatch_o || drdy_o));

  // R11
  flags_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({amatch_o, drdy_o}));

  // R3
  cmd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && cmd_i[1] && !fe_stop_i && !fe_addr_i) |=> (!amatch_o && !prec_o));

  // R3
  inert_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr_i && !cmd_i[1] && !fe_start_i && !fe_stop_i && !fe_addr_i &&
     !fe_byte_i && !fe_mack_i && !rx_ready_i) |=> $stable({amatch_o, drdy_o, prec_o}));

  // R4
  ack_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ack_pulse_o |-> (ack_nack_o == $past(cfg_ackact_i)));

  // R7
  tx_only_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_load_o |-> dir_o);

  // R9
  stop_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fe_stop_i && !cfg_group_i) |=> prec_o);
endmodule

bind i2c_cmd_seq i2cs_seq_chk u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .cmd_wr_i     (cmd_wr_i),
  .cmd_i        (cmd_i),
  .fe_start_i   (fe_start_i),
  .fe_stop_i    (fe_stop_i),
  .fe_addr_i    (fe_addr_i),
  .fe_byte_i    (fe_byte_i),
  .fe_mack_i    (fe_mack_i),
  .rx_ready_i   (rx_ready_i),
  .cfg_ackact_i (cfg_ackact_i),
  .cfg_group_i  (cfg_group_i),
  .amatch_o     (amatch_o),
  .drdy_o       (drdy_o),
  .prec_o       (prec_o),
  .dir_o        (dir_o),
  .scl_hold_o   (scl_hold_o),
  .ack_pulse_o  (ack_pulse_o),
  .ack_nack_o   (ack_nack_o),
  .tx_load_o    (tx_load_o)
);

// File: tb/i2c_cmd_seq_tb.sv
module i2c_cmd_seq_tb_top;
  localparam int CLK_P = 10;
  localparam logic [7:0] TXB = 8'hA5;

  localparam logic [3:0] OP_NOP = 4'd0, OP_STA = 4'd1, OP_ADR = 4'd2, OP_BYT = 4'd3,
                         OP_CMD = 4'd4, OP_MAK = 4'd5, OP_STP = 4'd6, OP_RRD = 4'd7;

  // exp bits: {amatch, drdy, prec, hold, dir, ackp, nack, arm, txload, release}
  typedef struct packed {
    logic [3:0] op;
    logic [7:0] arg;
    logic [2:0] cfg;   // {smart, group, ackact}
    logic [3:0] req;
    logic [9:0] exp;
  } vec_t;

  localparam int NV = 32;
  localparam vec_t VEC [NV] = '{
    '{OP_STA, 8'h00, 3'b000, 4'd2,  10'b0000000000}, // R2 start
    '{OP_ADR, 8'h00, 3'b000, 4'd2,  10'b1001000000}, // R2 write address
    '{OP_CMD, 8'h01, 3'b000, 4'd3,  10'b1001000000}, // R3 reserved code
    '{OP_CMD, 8'h00, 3'b000, 4'd3,  10'b1001000000}, // R3 no-op code
    '{OP_CMD, 8'h03, 3'b000, 4'd4,  10'b0000010100}, // R4 ack, arm
    '{OP_BYT, 8'h3C, 3'b000, 4'd5,  10'b0101000000}, // R5 byte
    '{OP_CMD, 8'h03, 3'b001, 4'd6,  10'b0000011100}, // R6 nack, rearm
    '{OP_BYT, 8'h55, 3'b000, 4'd5,  10'b0101000000}, // R5 byte
    '{OP_CMD, 8'h02, 3'b000, 4'd6,  10'b0000010001}, // R6 ack, release
    '{OP_STP, 8'h00, 3'b000, 4'd9,  10'b0010000001}, // R9 stop
    '{OP_STA, 8'h00, 3'b000, 4'd2,  10'b0010000000}, // R2 start
    '{OP_ADR, 8'h01, 3'b000, 4'd2,  10'b1011100000}, // R2 read address
    '{OP_CMD, 8'h03, 3'b000, 4'd4,  10'b0101110000}, // R4 ack, drdy
    '{OP_CMD, 8'h03, 3'b000, 4'd7,  10'b0000100010}, // R7 load
    '{OP_MAK, 8'h00, 3'b000, 4'd7,  10'b0101100000}, // R7 master ack
    '{OP_CMD, 8'h03, 3'b000, 4'd7,  10'b0000100010}, // R7 load
    '{OP_MAK, 8'h01, 3'b000, 4'd7,  10'b0101100000}, // R7 master nack
    '{OP_CMD, 8'h02, 3'b000, 4'd7,  10'b0000100001}, // R7 release, no ack
    '{OP_STA, 8'h00, 3'b000, 4'd2,  10'b0000000000}, // R2 dir cleared
    '{OP_STP, 8'h00, 3'b010, 4'd9,  10'b0010000001}, // R9 group, addressed
    '{OP_CMD, 8'h02, 3'b000, 4'd3,  10'b0000000001}, // R3 clears stop flag
    '{OP_STA, 8'h00, 3'b000, 4'd2,  10'b0000000000}, // R2
    '{OP_STP, 8'h00, 3'b010, 4'd9,  10'b0000000001}, // R9 group, not addressed
    '{OP_STA, 8'h00, 3'b000, 4'd2,  10'b0000000000}, // R2
    '{OP_ADR, 8'h00, 3'b000, 4'd2,  10'b1001000000}, // R2
    '{OP_CMD, 8'h03, 3'b000, 4'd4,  10'b0000010100}, // R4
    '{OP_BYT, 8'h9E, 3'b000, 4'd5,  10'b0101000000}, // R5
    '{OP_RRD, 8'h00, 3'b101, 4'd8,  10'b0000011100}, // R8 smart read acks
    '{OP_BYT, 8'h11, 3'b000, 4'd5,  10'b0101000000}, // R5
    '{OP_RRD, 8'h00, 3'b000, 4'd8,  10'b0101000000}, // R8 plain read inert
    '{OP_CMD, 8'h03, 3'b100, 4'd8,  10'b0000000100}, // R8 smart cmd no ack
    '{OP_STP, 8'h00, 3'b000, 4'd9,  10'b0010000001}  // R9
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_ackact_i = 0, cfg_smart_i = 0, cfg_group_i = 0;
  logic cmd_wr_i = 0;
  logic [1:0] cmd_i = '0;
  logic fe_start_i = 0, fe_stop_i = 0, fe_addr_i = 0, fe_rw_i = 0, fe_byte_i = 0;
  logic [7:0] fe_data_i = '0;
  logic fe_mack_i = 0, fe_nack_i = 0, rx_ready_i = 0;
  logic [7:0] tx_data_i = TXB;
  logic rx_valid_o, amatch_o, drdy_o, prec_o, dir_o, scl_hold_o, ack_pulse_o;
  logic ack_nack_o, rx_arm_o, tx_load_o, mnack_o, bus_release_o;
  logic [7:0] rx_data_o, tx_byte_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  i2c_cmd_seq dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_ackact_i(cfg_ackact_i), .cfg_smart_i(cfg_smart_i),
    .cfg_group_i(cfg_group_i), .cmd_wr_i(cmd_wr_i), .cmd_i(cmd_i),
    .fe_start_i(fe_start_i), .fe_stop_i(fe_stop_i), .fe_addr_i(fe_addr_i),
    .fe_rw_i(fe_rw_i), .fe_byte_i(fe_byte_i), .fe_data_i(fe_data_i),
    .fe_mack_i(fe_mack_i), .fe_nack_i(fe_nack_i), .tx_data_i(tx_data_i),
    .rx_ready_i(rx_ready_i), .rx_valid_o(rx_valid_o), .rx_data_o(rx_data_o),
    .amatch_o(amatch_o), .drdy_o(drdy_o), .prec_o(prec_o), .dir_o(dir_o),
    .scl_hold_o(scl_hold_o), .ack_pulse_o(ack_pulse_o), .ack_nack_o(ack_nack_o),
    .rx_arm_o(rx_arm_o), .tx_load_o(tx_load_o), .tx_byte_o(tx_byte_o),
    .mnack_o(mnack_o), .bus_release_o(bus_release_o)
  );

  function automatic logic [9:0] snap();
    return {amatch_o, drdy_o, prec_o, scl_hold_o, dir_o, ack_pulse_o,
            ack_nack_o, rx_arm_o, tx_load_o, bus_release_o};
  endfunction

  task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, got, exp);
    end
  endtask

  task automatic clear_pulses();
    cmd_wr_i = 0; fe_start_i = 0; fe_stop_i = 0; fe_addr_i = 0;
    fe_byte_i = 0; fe_mack_i = 0; rx_ready_i = 0;
  endtask

  // drive one event for one cycle; returns just after the capturing edge
  task automatic drive(input logic [3:0] op, input logic [7:0] arg, input logic [2:0] cfg);
    @(negedge clk);
    {cfg_smart_i, cfg_group_i, cfg_ackact_i} = cfg;
    case (op)
      OP_STA: fe_start_i = 1;
      OP_ADR: begin fe_addr_i = 1; fe_rw_i = arg[0]; end
      OP_BYT: begin fe_byte_i = 1; fe_data_i = arg; end
      OP_CMD: begin cmd_wr_i = 1; cmd_i = arg[1:0]; end
      OP_MAK: begin fe_mack_i = 1; fe_nack_i = arg[0]; end
      OP_STP: fe_stop_i = 1;
      OP_RRD: rx_ready_i = 1;
      default: ;
    endcase
    @(posedge clk);
    #1;
    clear_pulses();
  endtask

  initial begin
    #(CLK_P * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog expired actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    #1;
    // R1 reset state
    check("R1 reset outputs", {22'd0, snap()}, {22'd0, 10'b0000000001});

    for (int i = 0; i < NV; i++) begin
      drive(VEC[i].op, VEC[i].arg, VEC[i].cfg);
      checks++;
      if (snap() !== VEC[i].exp) begin
        errors++;
        $display("FAIL R%0d vector %0d actual=%b expected=%b",
                 VEC[i].req, i, snap(), VEC[i].exp);
      end
    end

    // R5 received byte presented on the stream port
    drive(OP_STA, 8'h00, 3'b000);
    drive(OP_ADR, 8'h00, 3'b000);
    drive(OP_CMD, 8'h03, 3'b000);
    drive(OP_BYT, 8'hC3, 3'b000);
    check("R5 rx_valid", {31'd0, rx_valid_o}, 32'd1);
    check("R5 rx_data", {24'd0, rx_data_o}, 32'h0000_00C3);
    drive(OP_NOP, 8'h00, 3'b000);
    check("R5 rx_data held", {24'd0, rx_data_o}, 32'h0000_00C3);

    // R7 transmit byte and master NACK status
    drive(OP_STA, 8'h00, 3'b000);
    drive(OP_ADR, 8'h01, 3'b000);
    drive(OP_CMD, 8'h03, 3'b000);
    check("R7 no rx_valid in read", {31'd0, rx_valid_o}, 32'd0);
    drive(OP_CMD, 8'h03, 3'b000);
    check("R7 tx_byte", {24'd0, tx_byte_o}, {24'd0, TXB});
    drive(OP_MAK, 8'h01, 3'b000);
    check("R7 mnack set", {31'd0, mnack_o}, 32'd1);
    drive(OP_CMD, 8'h03, 3'b000);
    drive(OP_MAK, 8'h00, 3'b000);
    check("R7 mnack clear", {31'd0, mnack_o}, 32'd0);

    // R10 command and stop in the same cycle
    drive(OP_STA, 8'h00, 3'b000);
    drive(OP_ADR, 8'h00, 3'b000);
    @(negedge clk);
    cmd_wr_i = 1; cmd_i = 2'd3; fe_stop_i = 1;
    @(posedge clk);
    #1;
    clear_pulses();
    check("R10 prec kept", {31'd0, prec_o}, 32'd1);
    check("R10 amatch cleared", {31'd0, amatch_o}, 32'd0);
    check("R10 released", {31'd0, bus_release_o}, 32'd1);

    // R11 start drops a pending flag and the hold
    drive(OP_STA, 8'h00, 3'b000);
    drive(OP_ADR, 8'h00, 3'b000);
    drive(OP_STA, 8'h00, 3'b000);
    check("R11 start drops amatch", {30'd0, amatch_o, scl_hold_o}, 32'd0);

    // R1 reset in the middle of a transfer
    drive(OP_ADR, 8'h01, 3'b000);
    @(negedge clk);
    rst_n = 0;
    @(posedge clk);
    #1;
    check("R1 mid-run reset", {22'd0, snap()}, {22'd0, 10'b0000000001});
    @(negedge clk);
    rst_n = 1;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule